// File: doc/BRIEF.md
# Range-Aware Radix-4 Booth Multiplier

This block forms the exact signed product of two two's-complement operands of equal width. Before any partial products are built, it works out how many bits each operand really needs: its effective range. The operand that needs fewer bits drives the radix-4 Booth digit recoder, and the other operand becomes the multiplicand. A narrow operand recodes into a run of zero digits in its upper positions, so more partial-product rows are all zero.

The rows are summed in a chain of full-width 3:2 counters, and one carry-propagate adder completes the sum. The registered result is exposed together with both detected ranges, so a downstream accumulator can judge how wide the product is. A flag also shows which operand was recoded. A new operand pair is accepted on any cycle where the valid input is high. Its result appears one cycle later. On idle cycles the output registers keep their previous contents.

Top module: `booth_range_mul`

## Requirements
- R1: When out_valid is high, prod equals the exact signed product of the operand pair accepted one cycle earlier, held in 2W bits. This includes the most negative value squared, and pairs where either operand is 0 or -1.
- R2: The reported range of an operand is the smallest n in 1..W for which -2^(n-1) <= v < 2^(n-1). It is 1 for both 0 and -1, and it is W for the most negative value.
- R3: ysel is 1 (Y recoded, X used as multiplicand) exactly when the range of Y is strictly less than the range of X. On equal ranges ysel is 0 and X is recoded.
- R4: out_valid is high in the cycle after a cycle with in_valid high, and low in the cycle after a cycle with in_valid low.
- R5: While rst_n is low, out_valid, prod, x_rng, y_rng and ysel are all 0.
- R6: After a cycle with in_valid low, prod, x_rng, y_rng and ysel keep the values they held before that cycle.
- R7: Exchanging the two operands gives the same prod and swaps the two range outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Accept x_in and y_in this cycle |
| x_in | input | W | Operand X, signed |
| y_in | input | W | Operand Y, signed |
| out_valid | output | 1 | Registered result is new this cycle |
| prod | output | 2W | Signed product |
| x_rng | output | $clog2(W+1) | Effective range of X |
| y_rng | output | $clog2(W+1) | Effective range of Y |
| ysel | output | 1 | 1 when Y was the recoded operand |

## Verification
Faults in this block show up one cycle after the operands are accepted. A wrong digit decode, a missing correction bit or a wrong row shift corrupts prod for the operand pairs that exercise that digit. Such faults show most clearly with the most negative value and with wide mixed-sign operands. A fault in range detection or in the operand swap shows at x_rng, y_rng and ysel. It shows in prod only if the datapath depends on the swap, so each pair is also applied in both orders and the two results are compared. A register that fails to hold shows on the first idle cycle.

// File: rtl/booth_range_mul.sv
module booth_range_mul #(
  parameter int W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [W-1:0]               x_in,
  input  logic [W-1:0]               y_in,
  output logic                       out_valid,
  output logic [2*W-1:0]             prod,
  output logic [$clog2(W+1)-1:0]     x_rng,
  output logic [$clog2(W+1)-1:0]     y_rng,
  output logic                       ysel
);
  localparam int PW = 2 * W;
  localparam int RW = $clog2(W + 1);
  localparam int ND = (W + 1) / 2;
  localparam int RX = 2 * ND;

  function automatic logic [RW-1:0] eff_range(input logic [W-1:0] v);
    eff_range = RW'(1);
    for (int i = 0; i < W - 1; i++)
      if (v[i] != v[W-1]) eff_range = RW'(i + 2);
  endfunction

  logic [RW-1:0] rx, ry;
  logic          swap;
  logic [W-1:0]  rec, mc;
  logic [RX:0]   rext;
  logic [PW-1:0] mcx;

  assign rx   = eff_range(x_in);
  assign ry   = eff_range(y_in);
  assign swap = ry < rx;
  assign rec  = swap ? y_in : x_in;
  assign mc   = swap ? x_in : y_in;
  assign rext = {RX'($signed(rec)), 1'b0};
  assign mcx  = PW'($signed(mc));

  logic [PW-1:0] pp [ND];
  logic [ND-1:0] negv;
  logic [PW-1:0] corr;

  for (genvar j = 0; j < ND; j++) begin : g_row
    logic [2:0]    b;
    logic          neg, one, two;
    logic [PW-1:0] pick, row;
    assign b    = rext[2*j+2 -: 3];
    assign neg  = b[2] & ~(b[1] & b[0]);
    assign one  = b[1] ^ b[0];
    assign two  = (b[2] & ~b[1] & ~b[0]) | (~b[2] & b[1] & b[0]);
    assign pick = one ? mcx : (two ? (mcx << 1) : '0);
    assign row  = neg ? ~pick : pick;
    assign pp[j]   = row << (2 * j);
    assign negv[j] = neg;
  end

  always_comb begin
    corr = '0;
    for (int j = 0; j < ND; j++) corr[2*j] = negv[j];
  end

  logic [PW-1:0] s [ND];
  logic [PW-1:0] c [ND];
  assign s[0] = pp[0];
  assign c[0] = corr;

  for (genvar k = 1; k < ND; k++) begin : g_csa
    assign s[k] = s[k-1] ^ c[k-1] ^ pp[k];
    assign c[k] = ((s[k-1] & c[k-1]) | (s[k-1] & pp[k]) | (c[k-1] & pp[k])) << 1;
  end

  logic [PW-1:0] sum;
  assign sum = s[ND-1] + c[ND-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      prod      <= '0;
      x_rng     <= '0;
      y_rng     <= '0;
      ysel      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        prod  <= sum;
        x_rng <= rx;
        y_rng <= ry;
        ysel  <= swap;
      end
    end
  end
endmodule

module booth_range_mul_chk #(
  parameter int W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic [W-1:0]           x_in,
  input logic [W-1:0]           y_in,
  input logic                   out_valid,
  input logic [2*W-1:0]         prod,
  input logic [$clog2(W+1)-1:0] x_rng,
  input logic [$clog2(W+1)-1:0] y_rng,
  input logic                   ysel
);
  localparam int PW = 2 * W;
  logic signed [PW-1:0] xe, ye, want;
  assign xe   = $signed(x_in);
  assign ye   = $signed(y_in);
  assign want = xe * ye;

  p_exact_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> prod == $past(want));
  p_range_bounds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (x_rng >= 1 && x_rng <= W && y_rng >= 1 && y_rng <= W));
  p_zero_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && x_in == '0) |=> x_rng == 1);
  p_pick_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ysel == (y_rng < x_rng));
  p_valid_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(prod) && $stable(x_rng) && $stable(y_rng) && $stable(ysel)));
endmodule

bind booth_range_mul booth_range_mul_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in), .y_in(y_in),
  .out_valid(out_valid), .prod(prod), .x_rng(x_rng), .y_rng(y_rng), .ysel(ysel)
);

// File: tb/tb_booth_range_mul.sv
module tb_booth_range_mul;
  localparam int W  = 16;
  localparam int PW = 2 * W;
  localparam int RW = $clog2(W + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] x_in = '0, y_in = '0;
  logic out_valid, ysel;
  logic [PW-1:0] prod;
  logic [RW-1:0] x_rng, y_rng;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  booth_range_mul #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in), .y_in(y_in),
    .out_valid(out_valid), .prod(prod), .x_rng(x_rng), .y_rng(y_rng), .ysel(ysel)
  );

  function automatic int ref_rng(input logic [W-1:0] v);
    int sv;
    sv = int'($signed(v));
    for (int n = 1; n <= W; n++)
      if (sv >= -(1 <<< (n - 1)) && sv < (1 <<< (n - 1))) return n;
    return W;
  endfunction

  function automatic logic [PW-1:0] ref_prod(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [PW-1:0] ae, be;
    ae = $signed(a);
    be = $signed(b);
    return ae * be;
  endfunction

  task automatic chk(input string req, input logic [PW-1:0] got, input logic [PW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b);
    int ra, rb;
    @(negedge clk);
    in_valid = 1'b1; x_in = a; y_in = b;
    @(negedge clk);
    ra = ref_rng(a); rb = ref_rng(b);
    chk("R1 product", prod, ref_prod(a, b));
    chk("R2 x range", PW'(x_rng), PW'(ra));
    chk("R2 y range", PW'(y_rng), PW'(rb));
    chk("R3 ysel", PW'(ysel), PW'(rb < ra));
    chk("R4 out_valid", PW'(out_valid), PW'(1));
  endtask

  task automatic t_reset;
    chk("R5 out_valid", PW'(out_valid), '0);
    chk("R5 prod", prod, '0);
    chk("R5 ranges", PW'({x_rng, y_rng, ysel}), '0);
  endtask

  task automatic t_corners;
    logic [W-1:0] mn = {1'b1, {(W-1){1'b0}}};
    logic [W-1:0] mx = {1'b0, {(W-1){1'b1}}};
    apply(mn, mn);
    apply(mn, mx);
    apply(mx, mx);
    apply('0, mn);
    apply('1, mn);
    apply('1, '1);
    apply('0, '0);
    apply(W'(1), mn);
    apply(W'(-2), W'(3));
  endtask

  task automatic t_choice;
    apply(W'(5), W'(-300));
    apply(W'(-300), W'(5));
    apply(W'(100), W'(-100));
    apply(W'(7), W'(-8));
    apply(W'(12345), W'(-1));
  endtask

  task automatic t_swap;
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] a, b;
      logic [PW-1:0] p1;
      logic [RW-1:0] ra1, rb1;
      a = W'($urandom);
      b = W'($urandom) >> ($urandom % W);
      apply(a, b);
      p1 = prod; ra1 = x_rng; rb1 = y_rng;
      apply(b, a);
      chk("R7 swapped product", prod, p1);
      chk("R7 swapped ranges", PW'({x_rng, y_rng}), PW'({rb1, ra1}));
    end
  endtask

  task automatic t_hold;
    logic [PW-1:0] p0;
    apply(W'(-1234), W'(77));
    p0 = prod;
    @(negedge clk);
    in_valid = 1'b0; x_in = W'(999); y_in = W'(-999);
    @(negedge clk);
    chk("R4 out_valid low", PW'(out_valid), '0);
    chk("R6 prod held", prod, p0);
    chk("R6 ranges held", PW'({x_rng, y_rng, ysel}),
        PW'({RW'(ref_rng(W'(-1234))), RW'(ref_rng(W'(77))), 1'b1}));
    @(negedge clk);
    chk("R6 prod still held", prod, p0);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] a, b;
      a = W'($signed(W'($urandom)) >>> ($urandom % W));
      b = W'($signed(W'($urandom)) >>> ($urandom % W));
      apply(a, b);
    end
  endtask

  initial begin
    #20000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_corners;
    t_choice;
    t_hold;
    t_swap;
    t_sweep;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule